// File: doc/BRIEF.md
# Hybrid Two-Tier Cache Placement Controller

This block controls a small last-level cache built from two storage tiers. One tier is fast and small. The other is dense, larger and slower. Each tier is a set-associative tag and data array with its own valid bits, dirty bits and least-recently-used ordering. Both tiers are indexed by the same low address bits.

The placement policy is simple:

- A line fetched from memory always lands in the dense tier.
- A line that is referenced again while it sits in the dense tier is moved into the fast tier.
- To make room for that move, the least recently used fast line drops back into the slot the promoted line left behind. It stays in the cache.
- Only a line pushed out of the dense tier leaves the cache. It goes out through the writeback port if it was modified.

A client issues one request at a time, carrying a line address and a read or write flag. It then waits for a single response pulse. The response reports the tier that held the line (miss, fast or dense) and the line data after the operation. On a miss, the controller asks memory for the line and holds that request until memory answers.

Top module: `hybrid_cache_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `fill_req` and `wb_valid` are 0. Every line is absent, so the first access to any address misses.
- R2: On a miss, the controller raises `fill_req` with `fill_addr` equal to the requested address. It holds both stable until `fill_valid` is seen. `rsp_valid` follows one cycle after the cycle in which `fill_valid` and `fill_req` are both high. `rsp_tier` then reads 2'b00.
- R3: A line that is present only in the dense tier responds with `rsp_tier` = 2'b10, exactly DENSE_LAT cycles after the request is accepted. It is moved into the fast tier, so its next access reports 2'b01.
- R4: A line in the fast tier responds with `rsp_tier` = 2'b01, exactly FAST_LAT cycles after acceptance.
- R5: A line installed from memory goes to the dense tier, never to the fast tier. When a promotion finds the fast set full, the fast least-recently-used line moves into the dense tier. Its next access reports 2'b10, not a miss.
- R6: When a miss finds the dense set full, the dense least-recently-used line leaves the cache and its next access misses. If that line is dirty, exactly one one-cycle `wb_valid` pulse carries its address and data. If it is clean, no pulse occurs.
- R7: Inside each tier, the victim is the valid line that was used least recently. A hit or an install makes a line most recent.
- R8: A line is resident in at most one tier at a time. The tier reported for every transaction matches an independent model of the placement policy.
- R9: From acceptance until its response pulse, `req_ready` stays low. Each accepted request yields exactly one `rsp_valid` pulse, one cycle long.
- R10: The dirty state moves with the line on promotion and on demotion. A line written, then promoted, demoted and finally evicted from the dense tier is written back with the written data.
- R11: A write stores `req_wdata` in the line and marks it dirty, whether it hits or misses. `rsp_rdata` returns the line data after the operation: the write data for a write, the stored or fetched data for a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle; request taken on this cycle if valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Line address; low bits select the set |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_tier | output | 2 | 00 miss, 01 fast tier hit, 10 dense tier hit |
| rsp_rdata | output | DATA_W | Line data after the operation |
| fill_req | output | 1 | Line fetch requested from memory |
| fill_addr | output | ADDR_W | Address of the line being fetched |
| fill_valid | input | 1 | Memory returns the requested line |
| fill_data | input | DATA_W | Returned line data |
| wb_valid | output | 1 | One-cycle pulse: dirty line leaving the cache |
| wb_addr | output | ADDR_W | Address of the written-back line |
| wb_data | output | DATA_W | Data of the written-back line |

## Verification
The hardest case to reach from the ports is a dirty line that makes the whole round trip. It has to be written, promoted, demoted by a later promotion, and then aged out of a full dense set, and only then can its data be checked on the writeback port. The stimulus gets there by targeting a single set. It promotes enough distinct lines to push the written one back out of the fast tier, then issues a run of fresh misses to the same set until the dense tier overflows. A long pseudo-random sequence over a few sets then exercises the same paths in mixed order. A model that tracks the tier and recency of every address checks the reported tier, data and writeback after each transaction.

// File: rtl/hc_pkg.sv
`timescale 1ns/1ps
package hc_pkg;
  typedef enum logic [1:0] {
    TIER_MISS  = 2'b00,
    TIER_FAST  = 2'b01,
    TIER_DENSE = 2'b10
  } tier_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WAIT,
    ST_FILL
  } ctrl_st_e;
endpackage

// File: rtl/hc_lru.sv
`timescale 1ns/1ps
// Recency ordering of one set: age 0 is most recent, WAYS-1 the oldest.
module hc_lru #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] oldest
);
  logic [WAY_W-1:0] age [WAYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WAYS; w++) age[w] <= WAY_W'(w);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way) age[w] <= '0;
        else if (age[w] < age[touch_way]) age[w] <= age[w] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest = '0;
    for (int w = 0; w < WAYS; w++)
      if (age[w] == WAY_W'(WAYS - 1)) oldest = WAY_W'(w);
  end
endmodule

// File: rtl/hc_tier.sv
`timescale 1ns/1ps
// One storage tier: set-associative tag/data array with a single write port.
// Lookup and write share the set index; every write makes the way most recent.
module hc_tier #(
  parameter int SETS   = 2,
  parameter int WAYS   = 2,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SET_W-1:0]  lk_set,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              hit,
  output logic [WAY_W-1:0]  hit_way,
  output logic              hit_dirty,
  output logic [DATA_W-1:0] hit_data,
  output logic [WAY_W-1:0]  vic_way,
  output logic              vic_valid,
  output logic              vic_dirty,
  output logic [TAG_W-1:0]  vic_tag,
  output logic [DATA_W-1:0] vic_data,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_dirty,
  input  logic [DATA_W-1:0] wr_data
);
  logic              vld [SETS][WAYS];
  logic              drt [SETS][WAYS];
  logic [TAG_W-1:0]  tg  [SETS][WAYS];
  logic [DATA_W-1:0] dat [SETS][WAYS];
  logic [WAY_W-1:0]  oldest [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) vld[s][w] <= 1'b0;
    end else if (wr_en) begin
      vld[lk_set][wr_way] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      drt[lk_set][wr_way] <= wr_dirty;
      tg[lk_set][wr_way]  <= wr_tag;
      dat[lk_set][wr_way] <= wr_data;
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    hc_lru #(.WAYS(WAYS)) u_lru (
      .clk       (clk),
      .rst       (rst),
      .touch     (wr_en && (lk_set == SET_W'(s))),
      .touch_way (wr_way),
      .oldest    (oldest[s])
    );
  end

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld[lk_set][w] && tg[lk_set][w] == lk_tag) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
    hit_dirty = drt[lk_set][hit_way];
    hit_data  = dat[lk_set][hit_way];
    // an empty way is preferred; otherwise the least recently used one
    vic_way = oldest[lk_set];
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld[lk_set][w]) vic_way = WAY_W'(w);
    vic_valid = vld[lk_set][vic_way];
    vic_dirty = drt[lk_set][vic_way];
    vic_tag   = tg[lk_set][vic_way];
    vic_data  = dat[lk_set][vic_way];
  end
endmodule

// File: rtl/hybrid_cache_ctrl.sv
`timescale 1ns/1ps
module hybrid_cache_ctrl
  import hc_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 8,
  parameter int SETS       = 2,
  parameter int FAST_WAYS  = 2,
  parameter int DENSE_WAYS = 4,
  parameter int FAST_LAT   = 2,
  parameter int DENSE_LAT  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_tier,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - SET_W;
  localparam int FWAY_W = $clog2(FAST_WAYS);
  localparam int DWAY_W = $clog2(DENSE_WAYS);
  localparam int CNT_W  = $clog2(DENSE_LAT + 1);

  ctrl_st_e          state;
  logic [SET_W-1:0]  a_set;
  logic [TAG_W-1:0]  a_tag;
  logic              a_wr;
  logic [DATA_W-1:0] a_wdata;
  logic [CNT_W-1:0]  wait_cnt;
  logic [DWAY_W-1:0] vic_q;
  logic [DATA_W-1:0] new_data;

  logic              f_hit, f_hit_dirty, f_vic_valid, f_vic_dirty;
  logic [FWAY_W-1:0] f_hit_way, f_vic_way;
  logic [DATA_W-1:0] f_hit_data, f_vic_data;
  logic [TAG_W-1:0]  f_vic_tag;
  logic              d_hit, d_hit_dirty, d_vic_valid, d_vic_dirty;
  logic [DWAY_W-1:0] d_hit_way, d_vic_way;
  logic [DATA_W-1:0] d_hit_data, d_vic_data;
  logic [TAG_W-1:0]  d_vic_tag;

  logic              f_wr_en, f_wr_dirty;
  logic [FWAY_W-1:0] f_wr_way;
  logic              d_wr_en, d_wr_valid, d_wr_dirty;
  logic [DWAY_W-1:0] d_wr_way;
  logic [TAG_W-1:0]  d_wr_tag;
  logic [DATA_W-1:0] d_wr_data;

  wire in_lookup = (state == ST_LOOKUP);
  wire in_fill   = (state == ST_FILL);

  assign req_ready = (state == ST_IDLE);

  always_comb begin
    if (a_wr)         new_data = a_wdata;
    else if (in_fill) new_data = fill_data;
    else if (f_hit)   new_data = f_hit_data;
    else              new_data = d_hit_data;
  end

  // fast tier: refresh on a fast hit, receive the line on a promotion
  assign f_wr_en    = in_lookup && (f_hit || d_hit);
  assign f_wr_way   = f_hit ? f_hit_way : f_vic_way;
  assign f_wr_dirty = a_wr | (f_hit ? f_hit_dirty : d_hit_dirty);

  // dense tier: demoted fast victim takes the freed slot, or a fill installs
  assign d_wr_en    = (in_lookup && !f_hit && d_hit) || (in_fill && fill_valid);
  assign d_wr_way   = in_fill ? vic_q : d_hit_way;
  assign d_wr_valid = in_fill | f_vic_valid;
  assign d_wr_tag   = in_fill ? a_tag : f_vic_tag;
  assign d_wr_dirty = in_fill ? a_wr : f_vic_dirty;
  assign d_wr_data  = in_fill ? new_data : f_vic_data;

  hc_tier #(.SETS(SETS), .WAYS(FAST_WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_fast (
    .clk(clk), .rst(rst), .lk_set(a_set), .lk_tag(a_tag),
    .hit(f_hit), .hit_way(f_hit_way), .hit_dirty(f_hit_dirty), .hit_data(f_hit_data),
    .vic_way(f_vic_way), .vic_valid(f_vic_valid), .vic_dirty(f_vic_dirty),
    .vic_tag(f_vic_tag), .vic_data(f_vic_data),
    .wr_en(f_wr_en), .wr_way(f_wr_way), .wr_valid(1'b1), .wr_tag(a_tag),
    .wr_dirty(f_wr_dirty), .wr_data(new_data)
  );

  hc_tier #(.SETS(SETS), .WAYS(DENSE_WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dense (
    .clk(clk), .rst(rst), .lk_set(a_set), .lk_tag(a_tag),
    .hit(d_hit), .hit_way(d_hit_way), .hit_dirty(d_hit_dirty), .hit_data(d_hit_data),
    .vic_way(d_vic_way), .vic_valid(d_vic_valid), .vic_dirty(d_vic_dirty),
    .vic_tag(d_vic_tag), .vic_data(d_vic_data),
    .wr_en(d_wr_en), .wr_way(d_wr_way), .wr_valid(d_wr_valid), .wr_tag(d_wr_tag),
    .wr_dirty(d_wr_dirty), .wr_data(d_wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_tier  <= TIER_MISS;
      rsp_rdata <= '0;
      fill_req  <= 1'b0;
      fill_addr <= '0;
      wb_valid  <= 1'b0;
      wb_addr   <= '0;
      wb_data   <= '0;
      wait_cnt  <= '0;
      vic_q     <= '0;
      a_set     <= '0;
      a_tag     <= '0;
      a_wr      <= 1'b0;
      a_wdata   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      wb_valid  <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          a_set   <= req_addr[SET_W-1:0];
          a_tag   <= req_addr[ADDR_W-1:SET_W];
          a_wr    <= req_write;
          a_wdata <= req_wdata;
          state   <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          rsp_rdata <= new_data;
          if (f_hit) begin
            rsp_tier <= TIER_FAST;
            wait_cnt <= CNT_W'(FAST_LAT - 2);
            state    <= ST_WAIT;
          end else if (d_hit) begin
            rsp_tier <= TIER_DENSE;
            wait_cnt <= CNT_W'(DENSE_LAT - 2);
            state    <= ST_WAIT;
          end else begin
            rsp_tier  <= TIER_MISS;
            vic_q     <= d_vic_way;
            fill_req  <= 1'b1;
            fill_addr <= {a_tag, a_set};
            state     <= ST_FILL;
            if (d_vic_valid && d_vic_dirty) begin
              wb_valid <= 1'b1;
              wb_addr  <= {d_vic_tag, a_set};
              wb_data  <= d_vic_data;
            end
          end
        end
        ST_WAIT: begin
          if (wait_cnt == '0) begin
            rsp_valid <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        ST_FILL: if (fill_valid) begin
          fill_req  <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_rdata <= new_data;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hc_check.sv
`timescale 1ns/1ps
module hc_check #(
  parameter int ADDR_W    = 6,
  parameter int FAST_LAT  = 2,
  parameter int DENSE_LAT = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [1:0]        rsp_tier,
  input logic              fill_req,
  input logic              fill_valid,
  input logic [ADDR_W-1:0] fill_addr,
  input logic              wb_valid,
  input logic              f_hit,
  input logic              d_hit
);
  logic [7:0] cyc;

  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (req_valid && req_ready) cyc <= '0;
    else if (cyc != 8'hFF) cyc <= cyc + 1'b1;
  end

  a_r8_one_tier: assert property (@(posedge clk) disable iff (rst)
    !(f_hit && d_hit));

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r4_fast_latency: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_tier == 2'b01) |-> (cyc == 8'(FAST_LAT)));

  a_r3_dense_latency: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_tier == 2'b10) |-> (cyc == 8'(DENSE_LAT)));

  a_r2_fill_held: assert property (@(posedge clk) disable iff (rst)
    (fill_req && !fill_valid) |=> (fill_req && $stable(fill_addr)));

  a_r6_wb_one_cycle: assert property (@(posedge clk) disable iff (rst)
    wb_valid |=> !wb_valid);
endmodule

bind hybrid_cache_ctrl hc_check #(
  .ADDR_W(ADDR_W), .FAST_LAT(FAST_LAT), .DENSE_LAT(DENSE_LAT)
) u_hc_check (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_tier(rsp_tier), .fill_req(fill_req),
  .fill_valid(fill_valid), .fill_addr(fill_addr), .wb_valid(wb_valid),
  .f_hit(f_hit), .d_hit(d_hit)
);

// File: tb/tb_hybrid_cache_ctrl.sv
`timescale 1ns/1ps
module tb_hybrid_cache_ctrl;
  localparam int AW = 6, DW = 8, SETS = 2, FW = 2, DWY = 4, FLAT = 2, DLAT = 4;
  localparam int NADDR = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, fill_req, wb_valid;
  logic [1:0] rsp_tier;
  logic [DW-1:0] rsp_rdata, wb_data;
  logic [AW-1:0] fill_addr, wb_addr;
  logic fill_valid = 1'b0;
  logic [DW-1:0] fill_data = '0;

  always #2.5 clk = ~clk;

  hybrid_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETS(SETS), .FAST_WAYS(FW),
    .DENSE_WAYS(DWY), .FAST_LAT(FLAT), .DENSE_LAT(DLAT)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_tier(rsp_tier), .rsp_rdata(rsp_rdata),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid),
    .fill_data(fill_data), .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data));

  int n_checks = 0, n_fail = 0, cycles = 0;

  // placement model: per tier and set, addresses ordered most recent first
  int lst [2][SETS][4];
  int ln  [2][SETS];
  logic [DW-1:0] mem [NADDR];
  logic [DW-1:0] cdat [NADDR];
  bit mdirty [NADDR];

  logic [1:0] last_tier;
  logic [DW-1:0] last_data, last_wb_d;
  int last_wb_n, last_wb_a;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      summary();
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int find(input int t, input int s, input int a);
    for (int i = 0; i < ln[t][s]; i++) if (lst[t][s][i] == a) return i;
    return -1;
  endfunction

  task automatic remove_at(input int t, input int s, input int p);
    for (int i = p; i < ln[t][s] - 1; i++) lst[t][s][i] = lst[t][s][i+1];
    ln[t][s]--;
  endtask

  task automatic push_front(input int t, input int s, input int a);
    for (int i = ln[t][s] - 1; i >= 0; i--) lst[t][s][i+1] = lst[t][s][i];
    lst[t][s][0] = a;
    ln[t][s]++;
  endtask

  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0; fill_valid = 1'b0;
    for (int t = 0; t < 2; t++) for (int s = 0; s < SETS; s++) ln[t][s] = 0;
    for (int i = 0; i < NADDR; i++) mdirty[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic do_req(input int a, input bit wr, input logic [DW-1:0] wd);
    int s, pf, pd, v, k, fdly, ewb_n, ewb_a;
    logic [DW-1:0] ewb_d;
    logic [1:0] et;
    bit done;
    s = a % SETS; pf = find(0, s, a); pd = find(1, s, a);
    ewb_n = 0; ewb_a = 0; ewb_d = '0;
    if (pf >= 0) begin
      et = 2'b01; remove_at(0, s, pf); push_front(0, s, a);
    end else if (pd >= 0) begin
      et = 2'b10; remove_at(1, s, pd);
      if (ln[0][s] == FW) begin
        v = lst[0][s][FW-1]; remove_at(0, s, FW-1); push_front(1, s, v);
      end
      push_front(0, s, a);
    end else begin
      et = 2'b00;
      if (ln[1][s] == DWY) begin
        v = lst[1][s][DWY-1]; remove_at(1, s, DWY-1);
        if (mdirty[v]) begin ewb_n = 1; ewb_a = v; ewb_d = cdat[v]; mem[v] = cdat[v]; end
        mdirty[v] = 1'b0;
      end
      push_front(1, s, a); cdat[a] = mem[a]; mdirty[a] = 1'b0;
    end
    if (wr) begin cdat[a] = wd; mdirty[a] = 1'b1; end

    @(negedge clk);
    k = 0;
    while (!req_ready && k < 100) begin @(negedge clk); k++; end
    req_valid = 1'b1; req_addr = AW'(a); req_write = wr; req_wdata = wd;
    @(posedge clk); @(negedge clk); req_valid = 1'b0;
    k = 0; done = 1'b0; fdly = 0; last_wb_n = 0; last_wb_a = 0; last_wb_d = '0;
    while (!done && k < 200) begin
      @(posedge clk); k++; @(negedge clk);
      if (fill_valid) fill_valid = 1'b0;
      else if (fill_req) begin
        if (fdly == 2) begin
          chk("R2", "fill address", int'(fill_addr), a);
          fill_valid = 1'b1; fill_data = mem[fill_addr];
        end else fdly++;
      end
      if (wb_valid) begin last_wb_n++; last_wb_a = int'(wb_addr); last_wb_d = wb_data; end
      if (rsp_valid) begin done = 1'b1; last_tier = rsp_tier; last_data = rsp_rdata; end
      else if (req_ready) chk("R9", "ready while busy", 1, 0);
    end
    chk("R9", "response seen", int'(done), 1);
    chk("R8", "reported tier vs model", int'(last_tier), int'(et));
    chk("R11", "response data", int'(last_data), int'(cdat[a]));
    chk("R6", "writeback count", last_wb_n, ewb_n);
    if (ewb_n == 1) begin
      chk("R6", "writeback address", last_wb_a, ewb_a);
      chk("R6", "writeback data", int'(last_wb_d), int'(ewb_d));
    end
    if (et == 2'b01) chk("R4", "fast latency", k, FLAT);
    if (et == 2'b10) chk("R3", "dense latency", k, DLAT);
    @(negedge clk);
    chk("R9", "no second pulse", int'(rsp_valid), 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "ready after reset", int'(req_ready), 1);
    chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1", "fill_req after reset", int'(fill_req), 0);
    chk("R1", "wb_valid after reset", int'(wb_valid), 0);
    do_req(6, 1'b0, '0);
    chk("R1", "first access misses", int'(last_tier), 0);
  endtask

  task automatic t_promote();
    do_reset();
    do_req(4, 1'b0, '0);
    chk("R2", "new line misses", int'(last_tier), 0);
    do_req(4, 1'b0, '0);
    chk("R5", "fill went to dense tier", int'(last_tier), 2);
    do_req(4, 1'b0, '0);
    chk("R3", "promoted line now fast", int'(last_tier), 1);
    do_req(4, 1'b0, '0);
    chk("R4", "fast hit repeats", int'(last_tier), 1);
  endtask

  task automatic t_write();
    do_reset();
    do_req(9, 1'b1, 8'hA5);
    chk("R11", "write miss returns write data", int'(last_data), 'hA5);
    do_req(9, 1'b0, '0);
    chk("R11", "read after write", int'(last_data), 'hA5);
    do_req(9, 1'b1, 8'h3C);
    do_req(9, 1'b0, '0);
    chk("R11", "fast write then read", int'(last_data), 'h3C);
  endtask

  task automatic t_demote();
    do_reset();
    do_req(0, 1'b0, '0); do_req(0, 1'b0, '0);
    do_req(2, 1'b0, '0); do_req(2, 1'b0, '0);
    do_req(4, 1'b0, '0); do_req(4, 1'b0, '0);
    do_req(0, 1'b0, '0);
    chk("R5", "demoted line still in dense tier", int'(last_tier), 2);
    do_req(4, 1'b0, '0);
    chk("R7", "more recent fast line kept", int'(last_tier), 1);
    do_req(2, 1'b0, '0);
    chk("R7", "older fast line was the one demoted", int'(last_tier), 2);
  endtask

  task automatic t_evict();
    do_reset();
    do_req(1, 1'b1, 8'h77);
    do_req(3, 1'b0, '0); do_req(5, 1'b0, '0); do_req(7, 1'b0, '0);
    do_req(9, 1'b0, '0);
    chk("R6", "dirty dense victim written back", last_wb_n, 1);
    chk("R6", "victim address", last_wb_a, 1);
    do_req(11, 1'b0, '0);
    chk("R6", "clean victim gives no writeback", last_wb_n, 0);
    do_req(3, 1'b0, '0);
    chk("R6", "evicted line misses", int'(last_tier), 0);
    do_req(1, 1'b0, '0);
    chk("R6", "written data survives in memory", int'(last_data), 'h77);
  endtask

  task automatic t_dirty_travel();
    do_reset();
    do_req(1, 1'b1, 8'h5C);
    do_req(1, 1'b0, '0);
    do_req(3, 1'b0, '0); do_req(3, 1'b0, '0);
    do_req(5, 1'b0, '0); do_req(5, 1'b0, '0);
    do_req(7, 1'b0, '0); do_req(9, 1'b0, '0); do_req(11, 1'b0, '0);
    do_req(13, 1'b0, '0);
    chk("R10", "dirty line written back after round trip", last_wb_n, 1);
    chk("R10", "round trip writeback address", last_wb_a, 1);
    chk("R10", "round trip writeback data", int'(last_wb_d), 'h5C);
  endtask

  task automatic t_mix();
    int x;
    do_reset();
    x = 5;
    for (int i = 0; i < 120; i++) begin
      x = (x * 29 + 11) % 251;
      do_req(x % 14, (x % 5) == 0, DW'(x));
    end
  endtask

  initial begin
    for (int i = 0; i < NADDR; i++) mem[i] = DW'(i * 7 + 3);
    t_reset();
    t_promote();
    t_write();
    t_demote();
    t_evict();
    t_dirty_travel();
    t_mix();
    summary();
  end
endmodule